// File: doc/BRIEF.md
# Variable-Length Recursive Moving Average

This block keeps a running windowed sum of a signed sample stream by the recursive method. A comb stage forms the difference between the newest sample and a delayed sample taken from a shift register. An integrator then accumulates that difference. The sample rate never changes. Moving the notches is done by changing the window instead: a runtime code picks an integer window of 16, 15 or 14 samples by reading the delay line at an earlier tap.

A half-sample mode puts the mean of two neighbouring taps in place of the single delayed sample. This gives a first-order approximation of a window half a sample shorter. Every notch moves by a small fraction of its spacing, and the nulls become shallower. The two taps are added rather than halved. To match, the newest sample is doubled in both modes, so the output is always twice the weighted window sum and no bit is lost.

Any change of the length code or of the half-sample mode clears the shift register and the accumulator. This stops a stale comb state from leaving a lasting offset in the recursion. The valid flag then stays low until a full new window has been taken in.

Top module: `varlen_mavg`

## Requirements
- R1: With half_en low, after each accepted sample out_data equals 2 x the sum of the last N accepted samples. N is 16 for len_sel 0, 15 for len_sel 1 and 14 for len_sel 2. The result appears on the cycle after the sample is accepted.
- R2: With half_en high, out_data equals 2 x the sum of the newest N-1 accepted samples, plus the sample accepted N-1 samples before the newest.
- R3: len_sel value 3 selects a window of 16 samples, the same as value 0.
- R4: A cycle with in_valid low leaves out_data unchanged and drives out_valid low on the next cycle.
- R5: out_valid is high exactly on the cycle after an accepted sample, and only when at least N samples have been accepted since the last clear.
- R6: When len_sel or half_en differs from its value in the previous cycle, all earlier samples are discarded and treated as zero. A sample accepted in that same cycle counts as the first sample of the new window.
- R7: After reset, out_data is 0 and out_valid is 0, the window holds zeros, and the configuration is len_sel 0 with half_en low.
- R8: A full window of full-scale positive or negative inputs gives the exact sum, with no wrap, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_data | input | DW | Signed input sample |
| len_sel | input | 2 | Window code: 0 gives 16, 1 gives 15, 2 gives 14, 3 gives 16 |
| half_en | input | 1 | Half-sample shortening of the window |
| out_valid | output | 1 | Full window present in out_data |
| out_data | output | DW+clog2(MAXLEN)+1 | Signed doubled window sum |

## Verification
The hardest situation to reach is a configuration change while the window is full. A stale delay line or accumulator would then leave a lasting error in the recursion. The stimulus switches length and mode in the middle of random streams. Some switches happen in a cycle that also accepts a sample and some in an idle cycle. One switch goes from code 0 to the reserved code 3, which selects the same length. The bench model restarts from zeros at each switch, so any leftover state shows up as a lasting mismatch.

// File: rtl/mavg_pkg.sv
// Shared helpers for the variable-length moving average.
// Assumes the window can only be shortened by 0, 1 or 2 taps.
package mavg_pkg;
    localparam int unsigned NUM_TRIM = 3;

    // Map the two-bit length code to the number of taps removed.
    function automatic logic [1:0] trim_of(input logic [1:0] code);
        return (code == 2'b11) ? 2'b00 : code;
    endfunction
endpackage

// File: rtl/mavg_delay_line.sv
// Shift register that holds the most recent DEPTH accepted samples.
// taps[k] holds the sample accepted k+1 acceptances ago.
// A clear zeroes every stage, and a sample shifted in during the same cycle lands in stage 0.
module mavg_delay_line #(
    parameter int DW    = 12,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      shift_en,
    input  logic [DW-1:0]             din,
    output logic [DEPTH-1:0][DW-1:0]  taps
);
    // Shift on each accepted sample, or empty the line on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (clear) begin
            taps    <= '0;
            taps[0] <= shift_en ? din : '0;
        end else if (shift_en) begin
            for (int i = DEPTH - 1; i > 0; i--) taps[i] <= taps[i-1];
            taps[0] <= din;
        end
    end

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !shift_en) |=> (taps == '0));
    a_r1_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clear) |=> (taps[1] == $past(taps[0])));
endmodule

// File: rtl/mavg_tap_sel.sv
// Forms the delayed comb term from the delay line.
// Integer mode returns twice the oldest in-window tap.
// Half mode returns the sum of that tap and the tap one stage newer.
// Assumes DEPTH >= NUM_TRIM + 1.
module mavg_tap_sel
    import mavg_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0][DW-1:0] taps,
    input  logic [1:0]               trim,
    input  logic                     half,
    output logic signed [DW:0]       term
);
    logic signed [DW:0] cand [NUM_TRIM];

    for (genvar t = 0; t < NUM_TRIM; t++) begin : g_cand
        logic signed [DW-1:0] far_s;
        logic signed [DW-1:0] near_s;
        assign far_s  = taps[DEPTH-1-t];
        assign near_s = taps[DEPTH-2-t];
        // Candidate term for a window shortened by t taps.
        assign cand[t] = half ? ({far_s[DW-1], far_s} + {near_s[DW-1], near_s})
                              : {far_s, 1'b0};
    end

    // Pick the candidate that matches the selected length.
    always_comb begin
        term = cand[0];
        if (trim == 2'd1)      term = cand[1];
        else if (trim == 2'd2) term = cand[2];
    end

    initial a_r1_depth_ok: assert (DEPTH >= NUM_TRIM + 1);
endmodule

// File: rtl/mavg_integrator.sv
// Comb difference plus accumulator, and a fill counter for the valid flag.
// Assumes the delayed term is already forced to zero by the caller while clear is high.
// The accumulator wraps in two's complement, but AW is sized so the window sum never does.
module mavg_integrator #(
    parameter int DW    = 12,
    parameter int AW    = 17,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic [DW-1:0]        din,
    input  logic signed [DW:0]   delayed,
    input  logic [CW-1:0]        need,
    output logic signed [AW-1:0] acc,
    output logic                 valid
);
    logic signed [DW+1:0] comb;
    logic signed [AW-1:0] acc_base;
    logic [CW-1:0]        cnt, cnt_new;

    // Comb stage: the doubled newest sample minus the delayed term.
    always_comb comb = {din[DW-1], din, 1'b0} - {delayed[DW], delayed};

    // Work out the accumulator base and the next fill count.
    always_comb begin
        acc_base = clear ? '0 : acc;
        if (clear)                                cnt_new = en ? CW'(1) : '0;
        else if (en && (cnt < CW'(DEPTH)))        cnt_new = cnt + CW'(1);
        else                                      cnt_new = cnt;
    end

    // Accumulate the comb output and register the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            cnt   <= '0;
            valid <= 1'b0;
        end else begin
            acc   <= en ? acc_base + {{(AW-DW-2){comb[DW+1]}}, comb} : acc_base;
            cnt   <= cnt_new;
            valid <= en && (cnt_new >= need);
        end
    end

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(acc));
    a_r5_valid_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(en));
    a_r6_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt <= CW'(1)));
endmodule

// File: rtl/varlen_mavg.sv
// Top of the variable-length recursive moving average.
// Holds the last configuration and raises a clear when it changes.
// Assumes one sample per cycle at most, with no back-pressure.
module varlen_mavg
    import mavg_pkg::*;
#(
    parameter int DW     = 12,
    parameter int MAXLEN = 16,
    localparam int AW    = DW + $clog2(MAXLEN) + 1,
    localparam int CW    = $clog2(MAXLEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [1:0]    len_sel,
    input  logic          half_en,
    output logic          out_valid,
    output logic [AW-1:0] out_data
);
    logic [2:0]                 cfg_q;
    logic                       clear;
    logic [1:0]                 trim;
    logic [CW-1:0]              need;
    logic [MAXLEN-1:0][DW-1:0]  taps;
    logic signed [DW:0]         term, term_g;
    logic signed [AW-1:0]       acc;

    // Remember the configuration so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= {len_sel, half_en};
    end

    // Decode the window length and the clear condition.
    always_comb begin
        clear  = ({len_sel, half_en} != cfg_q);
        trim   = trim_of(len_sel);
        need   = CW'(MAXLEN) - CW'(trim);
        term_g = clear ? '0 : term;
    end

    mavg_delay_line #(.DW(DW), .DEPTH(MAXLEN)) u_line (
        .clk(clk), .rst_n(rst_n), .clear(clear), .shift_en(in_valid),
        .din(in_data), .taps(taps));

    mavg_tap_sel #(.DW(DW), .DEPTH(MAXLEN)) u_sel (
        .taps(taps), .trim(trim), .half(half_en), .term(term));

    mavg_integrator #(.DW(DW), .AW(AW), .DEPTH(MAXLEN), .CW(CW)) u_int (
        .clk(clk), .rst_n(rst_n), .clear(clear), .en(in_valid), .din(in_data),
        .delayed(term_g), .need(need), .acc(acc), .valid(out_valid));

    assign out_data = acc;

    a_r6_change_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid);
    a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/sim_varlen_mavg.sv
// Self-checking bench: sweeps every length code in both modes, with random and full-scale data.
module sim_varlen_mavg;
    localparam int DW = 12;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [1:0]    len_sel = '0;
    logic          half_en = 1'b0;
    logic          out_valid;
    logic [AW-1:0] out_data;

    int checks = 0;
    int failures = 0;
    int hist [16];
    int mcnt = 0;
    logic [2:0] mcfg = '0;
    logic [31:0] lf = 32'h1ACE_B00C;
    bit finished = 0;

    always #10 clk = ~clk;

    varlen_mavg #(.DW(DW), .MAXLEN(16)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .len_sel(len_sel), .half_en(half_en), .out_valid(out_valid), .out_data(out_data));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int window_len(input logic [1:0] code);
        return (code == 2'd3) ? 16 : 16 - int'(code);
    endfunction

    // One cycle: drive inputs, clock, update the model, then compare.
    task automatic step(input int x, input bit v, input logic [1:0] ls, input bit he);
        int n, exp, act;
        bit changed;
        string tag;
        in_valid = v; in_data = DW'(x); len_sel = ls; half_en = he;
        @(posedge clk);
        @(negedge clk);
        changed = ({ls, he} != mcfg);
        if (changed) begin
            foreach (hist[i]) hist[i] = 0;
            mcnt = 0;
            mcfg = {ls, he};
        end
        if (v) begin
            for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = x;
            if (mcnt < 16) mcnt++;
        end
        n = window_len(ls);
        exp = 0;
        for (int k = 0; k < n - 1; k++) exp += 2 * hist[k];
        exp += he ? hist[n-1] : 2 * hist[n-1];
        act = int'($signed(out_data));
        if (changed)     tag = "R6";
        else if (!v)     tag = "R4";
        else if (ls == 2'd3) tag = "R3";
        else if (he)     tag = "R2";
        else             tag = "R1";
        check(act == exp, tag, act, exp);
        check(out_valid == (v && mcnt >= n), "R5", int'(out_valid), int'(v && mcnt >= n));
    endtask

    function automatic int next_rand();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return int'($signed(lf[DW-1:0]));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_data == '0, "R7", int'($signed(out_data)), 0);
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
        foreach (hist[i]) hist[i] = 0;
        // Random data at every length code in both modes, with idle gaps.
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 60; s++) begin
                step(next_rand(), (s % 7) != 3, 2'(m >> 1), m[0]);
            end
        end
        // Change the configuration in an idle cycle, then from code 0 to the reserved code.
        for (int s = 0; s < 20; s++) step(next_rand(), 1'b1, 2'd0, 1'b0);
        step(0, 1'b0, 2'd1, 1'b1);
        for (int s = 0; s < 20; s++) step(next_rand(), 1'b1, 2'd1, 1'b1);
        for (int s = 0; s < 20; s++) step(next_rand(), 1'b1, 2'd0, 1'b0);
        for (int s = 0; s < 20; s++) step(next_rand(), 1'b1, 2'd3, 1'b0);
        // R8: full-scale windows in both modes.
        for (int s = 0; s < 20; s++) step(-2048, 1'b1, 2'd0, 1'b0);
        check(int'($signed(out_data)) == -65536, "R8", int'($signed(out_data)), -65536);
        for (int s = 0; s < 20; s++) step(2047, 1'b1, 2'd0, 1'b0);
        check(int'($signed(out_data)) == 65504, "R8", int'($signed(out_data)), 65504);
        for (int s = 0; s < 20; s++) step(-2048, 1'b1, 2'd2, 1'b1);
        check(int'($signed(out_data)) == -2048 * 27, "R8", int'($signed(out_data)), -2048 * 27);
        // R7: a reset in the middle of a stream brings the outputs back to zero.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(out_data == '0, "R7", int'($signed(out_data)), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule